// File: doc/BRIEF.md
# I2C Multimaster Bus-Busy Tracker

This block sits beside a local I2C master on a bus shared with other masters. It watches the SDA and SCL lines and keeps a bus-busy flag and a sticky bus-free event flag. The local master must not begin a transfer while another master holds the bus. After any reset the busy flag is only a guess taken from the line levels. The block therefore also reports whether that flag can be trusted yet.

Both raw lines pass through a two-flop synchronizer. Edges are found by comparing each synchronized sample with the one before it. Any sample with SDA low and SCL high marks the bus as busy. This covers a START and also an acknowledge slot seen in the middle of someone else's transfer. An SDA rise while SCL stays high is a STOP: it clears busy and raises the bus-free event.

A validation state machine has four states: `TRK_OFF`, `TRK_WAIT`, `TRK_TRUSTED` and `TRK_EXPIRED`. Its transitions are:
- Any state goes to `TRK_OFF` on reset or when `enable` is low.
- `TRK_OFF` goes to `TRK_WAIT` on `validate_req`.
- `TRK_WAIT` goes to `TRK_TRUSTED` on bus activity, or once both lines have been high for the idle window.
- `TRK_WAIT` goes to `TRK_EXPIRED` when the overall timeout runs out.
- `TRK_EXPIRED` goes back to `TRK_WAIT` on `validate_req`.
- `TRK_TRUSTED` stays where it is until it is disabled or reset.

Top module: `i2c_busy_tracker`

## Requirements
- R1: While reset is low or `enable` is low, `busy` is re-seeded every cycle from the synchronized lines. It is 1 only for SDA=0 with SCL=1, and 0 for the other three combinations.
- R2: While enabled, a synchronized sample with SDA=0 and SCL=1 sets `busy`. A raw line change shows on `busy` after the third rising edge that follows it.
- R3: While enabled, SDA going 0 to 1 in two successive samples, with SCL=1 in both, clears `busy` and sets `bus_free`. The STOP is seen on the third edge after the raw SDA rise.
- R4: `bus_free` is cleared by reset and by a one-cycle `free_clr` pulse. A STOP in the same cycle wins over the clear.
- R5: In `TRK_WAIT`, the edge that sees a busy-setting sample or a STOP moves the block to `TRK_TRUSTED`, and `valid`=1 after that edge.
- R6: In `TRK_WAIT`, `valid` rises after `IDLE_CYCLES` consecutive edges with both synchronized lines high. Any edge that sees a low line restarts the count. If the idle window and the timeout finish on the same edge, the idle window wins.
- R7: If validity is not reached within `TIMEOUT_CYCLES` edges of entering `TRK_WAIT`, `timeout` goes to 1 and `valid` stays 0. `timeout` holds until `validate_req` starts a new wait.
- R8: Reset or `enable`=0 forces `valid`=0 and `timeout`=0. `validate_req` is ignored while `enable` is low.
- R9: `start_ok` is 1 exactly when `valid`=1 and `busy`=0.
- R10: `validate_req` in `TRK_TRUSTED` has no effect, and `valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Tracking and validation enable |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| validate_req | input | 1 | One-cycle request to start validation |
| free_clr | input | 1 | One-cycle write-one-to-clear for `bus_free` |
| busy | output | 1 | Bus-busy flag |
| bus_free | output | 1 | Sticky STOP-seen event flag |
| valid | output | 1 | Busy flag is trustworthy |
| timeout | output | 1 | Validation gave up |
| start_ok | output | 1 | Local master may start a transfer |

## Verification
The assertions assume that `sda_in` and `scl_in` change at most once per clock. They also assume that `validate_req` and `free_clr` are single-cycle pulses, driven away from the clock edge. The bench keeps to this by changing lines and strobes only once, just after an edge. Between cases it waits at least three cycles so that the synchronizer has settled before a new request. The sweeps place a single low SCL sample, or a falling SDA, at every cycle offset inside a small idle window and timeout. This covers the restart of the idle count, the tie with the timeout, and the latency through the synchronizer.

// File: rtl/i2c_trk_pkg.sv
package i2c_trk_pkg;

    typedef enum logic [1:0] {
        TRK_OFF,
        TRK_WAIT,
        TRK_TRUSTED,
        TRK_EXPIRED
    } trk_state_e;

    // Counter width able to hold values 0 .. limit-1
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // No reset: the chain keeps sampling so seeding during reset sees real levels
    always_ff @(posedge clk) begin
        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/bus_cond.sv
module bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic free_clr,
    input  logic sda_s,
    input  logic scl_s,
    output logic sda_q,
    output logic scl_q,
    output logic busy,
    output logic bus_free,
    output logic activity,
    output logic lines_high
);
    logic seed;
    logic hold_low;
    logic stop_seen;

    assign seed       = ~sda_s & scl_s;
    assign hold_low   = ~sda_s & scl_s;
    assign stop_seen  = scl_s & scl_q & ~sda_q & sda_s;
    assign lines_high = sda_s & scl_s;
    assign activity   = enable & (hold_low | stop_seen);

    always_ff @(posedge clk) begin
        sda_q <= sda_s;
        scl_q <= scl_s;
        if (!rst_n) begin
            busy     <= seed;
            bus_free <= 1'b0;
        end else if (!enable) begin
            busy <= seed;
            if (free_clr) bus_free <= 1'b0;
        end else if (stop_seen) begin
            busy     <= 1'b0;
            bus_free <= 1'b1;
        end else begin
            if (hold_low) busy     <= 1'b1;
            if (free_clr) bus_free <= 1'b0;
        end
    end
endmodule

// File: rtl/run_counter.sv
module run_counter
    import i2c_trk_pkg::*;
#(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic hit
);
    localparam int unsigned W = cnt_width(LIMIT);

    logic [W-1:0] cnt;

    assign hit = inc & (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (inc)        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_busy_tracker.sv
module i2c_busy_tracker
    import i2c_trk_pkg::*;
#(
    parameter int          SYNC_STAGES    = 2,
    parameter int unsigned IDLE_CYCLES    = 1_000_000,
    parameter int unsigned TIMEOUT_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sda_in,
    input  logic scl_in,
    input  logic validate_req,
    input  logic free_clr,
    output logic busy,
    output logic bus_free,
    output logic valid,
    output logic timeout,
    output logic start_ok
);
    trk_state_e state, nxt;

    logic [1:0] lines_s;
    logic       sda_s, scl_s, sda_q, scl_q;
    logic       activity, lines_high;
    logic       idle_hit, tmo_hit;
    logic       in_wait;

    line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk (clk),
        .d   ({sda_in, scl_in}),
        .q   (lines_s)
    );
    assign sda_s = lines_s[1];
    assign scl_s = lines_s[0];

    bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .free_clr   (free_clr),
        .sda_s      (sda_s),
        .scl_s      (scl_s),
        .sda_q      (sda_q),
        .scl_q      (scl_q),
        .busy       (busy),
        .bus_free   (bus_free),
        .activity   (activity),
        .lines_high (lines_high)
    );

    assign in_wait = (state == TRK_WAIT);

    run_counter #(.LIMIT(IDLE_CYCLES)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (~in_wait | ~lines_high),
        .inc   (lines_high),
        .hit   (idle_hit)
    );

    run_counter #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (~in_wait),
        .inc   (1'b1),
        .hit   (tmo_hit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TRK_OFF;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            TRK_OFF:     if (validate_req) nxt = TRK_WAIT;
            TRK_WAIT: begin
                if (activity || idle_hit) nxt = TRK_TRUSTED;
                else if (tmo_hit)         nxt = TRK_EXPIRED;
            end
            TRK_TRUSTED: nxt = TRK_TRUSTED;
            TRK_EXPIRED: if (validate_req) nxt = TRK_WAIT;
        endcase
        if (!enable) nxt = TRK_OFF;
    end

    // Outputs
    always_comb begin
        valid    = (state == TRK_TRUSTED);
        timeout  = (state == TRK_EXPIRED);
        start_ok = valid & ~busy;
    end
endmodule

// File: rtl/i2c_busy_tracker_chk.sv
module i2c_busy_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic validate_req,
    input logic free_clr,
    input logic sda_s,
    input logic scl_s,
    input logic sda_q,
    input logic scl_q,
    input logic busy,
    input logic bus_free,
    input logic valid,
    input logic timeout
);
    a_r1_seed: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> busy == $past(~sda_s & scl_s));

    a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
        enable && scl_s && !sda_s |=> busy);

    a_r3_stop: assert property (@(posedge clk) disable iff (!rst_n)
        enable && scl_q && scl_s && !sda_q && sda_s |=> !busy && bus_free);

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        free_clr && !(enable && scl_q && scl_s && !sda_q && sda_s) |=> !bus_free);

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && timeout));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        timeout && enable && !validate_req |=> timeout);

    a_r8_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !valid && !timeout);

    a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
        valid && enable |=> valid);
endmodule

bind i2c_busy_tracker i2c_busy_tracker_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .validate_req (validate_req),
    .free_clr     (free_clr),
    .sda_s        (sda_s),
    .scl_s        (scl_s),
    .sda_q        (sda_q),
    .scl_q        (scl_q),
    .busy         (busy),
    .bus_free     (bus_free),
    .valid        (valid),
    .timeout      (timeout)
);

// File: tb/i2c_busy_tracker_test.sv
module i2c_busy_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int IDLE = 6;
    localparam int TMO  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic sda = 1'b1;
    logic scl = 1'b1;
    logic req = 1'b0;
    logic fclr = 1'b0;
    logic busy, bus_free, valid, timeout, start_ok;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_busy_tracker #(
        .SYNC_STAGES(2), .IDLE_CYCLES(IDLE), .TIMEOUT_CYCLES(TMO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sda_in(sda), .scl_in(scl),
        .validate_req(req), .free_clr(fclr), .busy(busy), .bus_free(bus_free),
        .valid(valid), .timeout(timeout), .start_ok(start_ok)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic rearm();
        enable = 1'b0; sda = 1'b1; scl = 1'b1; req = 1'b0;
        repeat (2) step();
        enable = 1'b1;
        repeat (3) step();
    endtask

    // mode 0: lines high; 1: one low SCL sample at q; 2: SDA low from q on; 3: SCL low throughout
    task automatic run(input int mode, input int q, output int first_j, output int kind);
        first_j = -1;
        kind = 0;
        for (int j = 0; j < 30; j++) begin
            case (mode)
                1: scl = (j == q) ? 1'b0 : 1'b1;
                2: if (j >= q) sda = 1'b0;
                3: scl = 1'b0;
                default: ;
            endcase
            req = (j == 0);
            step();
            if (first_j < 0 && (valid || timeout)) begin
                first_j = j;
                kind = valid ? 1 : 2;
            end
        end
        req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int fj, kd, ej, ek;

        // R1 / R8: seed under reset for all four line combinations
        for (int c = 0; c < 4; c++) begin
            sda = c[1]; scl = c[0]; rst_n = 1'b0;
            repeat (4) step();
            check($sformatf("R1 seed sda=%0d scl=%0d", c[1], c[0]), busy, (c == 1) ? 1 : 0);
            check("R8 reset valid", valid, 0);
            check("R8 reset timeout", timeout, 0);
            check("R4 reset bus_free", bus_free, 0);
        end
        rst_n = 1'b1;

        // R6: plain idle window
        rearm();
        run(0, 0, fj, kd);
        check("R6 idle latency", fj, IDLE);
        check("R6 idle kind", kd, 1);
        check("R9 start_ok idle", start_ok, 1);

        // R6: single low SCL sample at every offset
        for (int q = 0; q <= 10; q++) begin
            rearm();
            run(1, q, fj, kd);
            ej = (q + 2 <= IDLE) ? q + 2 + IDLE : IDLE;
            ek = (ej <= TMO) ? 1 : 2;
            if (ek == 2) ej = TMO;
            check($sformatf("R6 glitch q=%0d latency", q), fj, ej);
            check($sformatf("R6 glitch q=%0d kind", q), kd, ek);
        end

        // R7: timeout, hold, and retry
        rearm();
        run(3, 0, fj, kd);
        check("R7 timeout latency", fj, TMO);
        check("R7 timeout kind", kd, 2);
        check("R7 valid low", valid, 0);
        scl = 1'b1;
        repeat (3) step();
        check("R7 timeout holds", timeout, 1);
        run(0, 0, fj, kd);
        check("R7 retry latency", fj, IDLE);
        check("R7 retry kind", kd, 1);

        // R2 / R5 / R9: falling SDA at each offset validates on sight
        for (int q = 0; q <= 3; q++) begin
            rearm();
            run(2, q, fj, kd);
            check($sformatf("R5 event q=%0d latency", q), fj, q + 2);
            check($sformatf("R5 event q=%0d kind", q), kd, 1);
            check($sformatf("R2 busy q=%0d", q), busy, 1);
            check("R9 start_ok while busy", start_ok, 0);
        end

        // R3: STOP
        sda = 1'b1;
        repeat (2) step();
        check("R3 busy before stop seen", busy, 1);
        step();
        check("R3 busy cleared", busy, 0);
        check("R3 bus_free set", bus_free, 1);
        check("R9 start_ok after stop", start_ok, 1);

        // R10: request in trusted state
        req = 1'b1; step(); req = 1'b0;
        repeat (10) step();
        check("R10 valid kept", valid, 1);

        // R4: write-one-to-clear
        fclr = 1'b1; step(); fclr = 1'b0;
        check("R4 bus_free cleared", bus_free, 0);

        // R8: disable drops valid and ignores requests
        enable = 1'b0; step();
        check("R8 disable valid", valid, 0);
        req = 1'b1; step(); req = 1'b0;
        enable = 1'b1;
        repeat (20) step();
        check("R8 req ignored valid", valid, 0);
        check("R8 req ignored timeout", timeout, 0);

        // R8 / R4: reset clears valid and bus_free
        run(0, 0, fj, kd);
        sda = 1'b0; repeat (4) step();
        sda = 1'b1; repeat (4) step();
        check("R4 bus_free before reset", bus_free, 1);
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        check("R8 reset clears valid", valid, 0);
        check("R4 reset clears bus_free", bus_free, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule